// File: doc/BRIEF.md
# Parameter-Set NAL Writer

This block emits the two parameter-set NAL units a baseline-profile video decoder needs before it can parse any picture: the sequence set and, right after it, the picture set. A single start pulse launches one pass that serializes both units one bit per clock. Each syntax element is either a fixed-width value or an unsigned Exp-Golomb code (for a value v: floor(log2(v+1)) zero bits, then v+1 in binary). The bits are packed MSB-first into bytes. The frame size is the only variable content. It arrives as width-in-macroblocks-minus-one and height-in-macroblocks-minus-one and is captured when the pass starts. Every other element holds a fixed baseline constant.

Bytes leave through a valid/ready handshake. When the prefix input is high at start, each NAL unit is preceded by the four-byte start code 00 00 00 01. A one-cycle done pulse marks the end of the pass. The host issues one pass at stream start and may issue another before any IDR picture.

Top module: `paramset_writer`

## Requirements
- R1: After reset, byteValid and doneOut are both 0.
- R2: With prefixEn=0 and frame size 21/17 (352x288), the first unit is exactly 67 42 00 28 DA 05 82 59. It carries: header 0x67; profile 66 in 8 bits; 8 zero bits (constraint flags and reserved); level 40 in 8 bits; ue set id 0; ue frame-number width 0; ue order type 2; ue reference count 1; gaps flag 0; ue width; ue height; frame-only flag 1; direct-inference flag 1; cropping flag 0; usability flag 0.
- R3: The second unit is exactly 68 CE 38 80. It carries: header 0x68; ue picture-set id 0; ue set id 0; entropy flag 0; order-present flag 0; ue slice groups 0; two ue active-reference values 0; weighted flag 0; 2-bit bipred code 00; three signed offsets of 0, each coded as the single bit 1; deblock-control flag 0; constrained-intra flag 0; redundant-count flag 0.
- R4: The width and height fields are unsigned Exp-Golomb codes of widthMbsM1 and heightMbsM1, so any frame size yields the matching byte sequence.
- R5: With prefixEn=1, each unit is preceded by 00 00 00 01 (20 bytes in total for 352x288). With prefixEn=0, no start code is sent (12 bytes).
- R6: Each unit ends with a stop bit 1, followed by zero bits up to the next byte boundary.
- R7: While byteValid=1 and byteReady=0, byteValid stays 1 and byteData holds its value. Under any ready pattern, no byte is lost or repeated.
- R8: doneOut is high for exactly one cycle per pass. It rises on the clock edge that follows the edge accepting the final byte.
- R9: A start pulse during a pass is ignored. Frame-size and prefix inputs that change after the start cycle do not affect the pass in progress.
- R10: A new pass may be started after done, and it reproduces the full output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Starts a pass when idle |
| prefixEn | input | 1 | Send start code before each unit |
| widthMbsM1 | input | MB_DIM_W | Frame width in macroblocks minus one |
| heightMbsM1 | input | MB_DIM_W | Frame height in macroblocks minus one |
| byteReady | input | 1 | Consumer accepts byteData |
| byteValid | output | 1 | byteData holds a byte |
| byteData | output | 8 | Output byte |
| doneOut | output | 1 | One-cycle end-of-pass pulse |

## Verification
The bench aims at bit-alignment: Exp-Golomb codes of several lengths straddle byte boundaries (sizes 21/17, 79/44 and 0/0). A wrong code length or bit order here shifts every later byte. The stop-bit padding is checked where a unit's last bit lands mid-byte, since a design that pads wrongly emits an extra or a short final byte. Backpressure from alternating and pseudo-random ready patterns shows whether a design that shifts while stalled drops or duplicates bytes. A mid-pass start pulse and frame-size change would corrupt the stream or yield a second done pulse if the inputs were not captured at start.

// File: rtl/paramset_pkg.sv
package paramset_pkg;

  localparam int FIELD_W = 32;
  localparam int LEN_W   = 6;
  localparam int IDX_W   = 6;
  localparam int DIM_W   = 16;

  // Field indices whose position drives sequencing
  localparam logic [IDX_W-1:0] SPS_SC   = 6'd0;
  localparam logic [IDX_W-1:0] SPS_HDR  = 6'd1;
  localparam logic [IDX_W-1:0] SPS_STOP = 6'd16;
  localparam logic [IDX_W-1:0] PPS_SC   = 6'd17;
  localparam logic [IDX_W-1:0] PPS_HDR  = 6'd18;
  localparam logic [IDX_W-1:0] PPS_STOP = 6'd34;

  typedef struct packed {
    logic [FIELD_W-1:0] val;
    logic [LEN_W-1:0]   len;
  } field_t;

  typedef struct packed {
    logic shiftEn;
    logic bitVal;
  } strobe_t;

  function automatic field_t fx(input logic [FIELD_W-1:0] v, input int unsigned n);
    field_t f;
    f.val = v;
    f.len = LEN_W'(n);
    return f;
  endfunction

  // Unsigned Exp-Golomb: emitting v+1 over 2n-1 bits gives the leading zeros
  function automatic field_t ue(input logic [DIM_W-1:0] v);
    field_t f;
    logic [DIM_W:0] x;
    int unsigned n;
    x = (DIM_W+1)'(v) + 1'b1;
    n = 1;
    for (int i = 0; i <= DIM_W; i++) if (x[i]) n = i + 1;
    f.val = FIELD_W'(x);
    f.len = LEN_W'(2 * n - 1);
    return f;
  endfunction

  function automatic field_t fieldAt(input logic [IDX_W-1:0] idx,
                                     input logic [DIM_W-1:0] w,
                                     input logic [DIM_W-1:0] h);
    case (idx)
      6'd0, 6'd17: return fx(32'h0000_0001, 32);
      6'd1:  return fx(32'h67, 8);
      6'd2:  return fx(32'd66, 8);
      6'd3:  return fx(32'd0, 8);
      6'd4:  return fx(32'd40, 8);
      6'd5, 6'd6: return ue(16'd0);
      6'd7:  return ue(16'd2);
      6'd8:  return ue(16'd1);
      6'd9:  return fx(32'd0, 1);
      6'd10: return ue(w);
      6'd11: return ue(h);
      6'd12, 6'd13: return fx(32'd1, 1);
      6'd14, 6'd15: return fx(32'd0, 1);
      6'd16, 6'd34: return fx(32'd1, 1);
      6'd18: return fx(32'h68, 8);
      6'd19, 6'd20: return ue(16'd0);
      6'd21, 6'd22: return fx(32'd0, 1);
      6'd23, 6'd24, 6'd25: return ue(16'd0);
      6'd26: return fx(32'd0, 1);
      6'd27: return fx(32'd0, 2);
      6'd28, 6'd29, 6'd30: return fx(32'd1, 1);
      default: return fx(32'd0, 1);
    endcase
  endfunction

endpackage

// File: rtl/paramset_ctrl.sv
module paramset_ctrl
  import paramset_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic             prefixEn,
  input  logic [DIM_W-1:0] widthIn,
  input  logic [DIM_W-1:0] heightIn,
  input  logic             stall,
  input  logic             aligned,
  input  logic             outValidIn,
  output strobe_t          strobe,
  output logic             doneOut
);

  typedef enum logic [1:0] {IDLE, SHIFT, PAD, DRAIN} state_t;

  state_t             state;
  logic [IDX_W-1:0]   idx;
  logic [LEN_W-1:0]   bitsLeft;
  logic               prefixQ;
  logic [DIM_W-1:0]   widthQ, heightQ;
  logic               doneQ;
  field_t             curField, nextField, startField, ppsField;
  logic [IDX_W-1:0]   startIdx, ppsIdx;

  assign startIdx   = prefixEn ? SPS_SC : SPS_HDR;
  assign ppsIdx     = prefixQ ? PPS_SC : PPS_HDR;
  assign curField   = fieldAt(idx, widthQ, heightQ);
  assign nextField  = fieldAt(idx + 1'b1, widthQ, heightQ);
  assign startField = fieldAt(startIdx, widthIn, heightIn);
  assign ppsField   = fieldAt(ppsIdx, widthQ, heightQ);

  always_comb begin
    strobe.shiftEn = ((state == SHIFT) || (state == PAD && !aligned)) && !stall;
    strobe.bitVal  = (state == SHIFT) ? curField.val[5'(bitsLeft - 1'b1)] : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= IDLE;
      idx      <= '0;
      bitsLeft <= '0;
      prefixQ  <= 1'b0;
      widthQ   <= '0;
      heightQ  <= '0;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (state)
        IDLE: if (startIn) begin
          prefixQ  <= prefixEn;
          widthQ   <= widthIn;
          heightQ  <= heightIn;
          idx      <= startIdx;
          bitsLeft <= startField.len;
          state    <= SHIFT;
        end
        SHIFT: if (!stall) begin
          if (bitsLeft == 1) begin
            if (idx == SPS_STOP || idx == PPS_STOP) begin
              state <= PAD;
            end else begin
              idx      <= idx + 1'b1;
              bitsLeft <= nextField.len;
            end
          end else begin
            bitsLeft <= bitsLeft - 1'b1;
          end
        end
        PAD: if (aligned) begin
          if (idx == SPS_STOP) begin
            idx      <= ppsIdx;
            bitsLeft <= ppsField.len;
            state    <= SHIFT;
          end else begin
            state <= DRAIN;
          end
        end
        DRAIN: if (!outValidIn) begin
          doneQ <= 1'b1;
          state <= IDLE;
        end
        default: state <= IDLE;
      endcase
    end
  end

  assign doneOut = doneQ;

  // R7
  no_shift_on_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> !strobe.shiftEn);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  // R8
  done_after_drain_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> !outValidIn);

  // R6
  idle_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == IDLE) |-> aligned);

endmodule

// File: rtl/paramset_dp.sv
module paramset_dp
  import paramset_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic              outReady,
  output logic              outValid,
  output logic [BYTE_W-1:0] outByte,
  output logic              stall,
  output logic              aligned
);

  logic [BYTE_W-2:0] byteAcc;
  logic [CNT_W-1:0]  bitCnt;
  logic              lastBit;

  assign lastBit = (bitCnt == CNT_W'(BYTE_W - 1));
  assign stall   = outValid && !outReady;
  assign aligned = (bitCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteAcc  <= '0;
      bitCnt   <= '0;
      outValid <= 1'b0;
      outByte  <= '0;
    end else begin
      if (outValid && outReady) outValid <= 1'b0;
      if (strobe.shiftEn) begin
        if (lastBit) begin
          outByte  <= {byteAcc, strobe.bitVal};
          outValid <= 1'b1;
          bitCnt   <= '0;
        end else begin
          byteAcc <= {byteAcc[BYTE_W-3:0], strobe.bitVal};
          bitCnt  <= bitCnt + 1'b1;
        end
      end
    end
  end

  // R7
  hold_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outByte)));

endmodule

// File: rtl/paramset_writer.sv
module paramset_writer
  import paramset_pkg::*;
#(
  parameter int MB_DIM_W = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startIn,
  input  logic                prefixEn,
  input  logic [MB_DIM_W-1:0] widthMbsM1,
  input  logic [MB_DIM_W-1:0] heightMbsM1,
  input  logic                byteReady,
  output logic                byteValid,
  output logic [7:0]          byteData,
  output logic                doneOut
);

  strobe_t strobe;
  logic    stall, aligned;

  paramset_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .startIn    (startIn),
    .prefixEn   (prefixEn),
    .widthIn    (DIM_W'(widthMbsM1)),
    .heightIn   (DIM_W'(heightMbsM1)),
    .stall      (stall),
    .aligned    (aligned),
    .outValidIn (byteValid),
    .strobe     (strobe),
    .doneOut    (doneOut)
  );

  paramset_dp #(.BYTE_W(8)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .outReady (byteReady),
    .outValid (byteValid),
    .outByte  (byteData),
    .stall    (stall),
    .aligned  (aligned)
  );

endmodule

// File: tb/paramset_writer_tb_top.sv
module paramset_writer_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startIn = 1'b0;
  logic       prefixEn = 1'b0;
  logic [8:0] widthMbsM1 = '0;
  logic [8:0] heightMbsM1 = '0;
  logic       byteReady = 1'b0;
  logic       byteValid;
  logic [7:0] byteData;
  logic       doneOut;

  always #2 clk = ~clk;

  paramset_writer #(.MB_DIM_W(9)) dut_i (.*);

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int readyMode = 0;
  logic [7:0] lfsr = 8'h5a;
  logic holdPrev = 0;
  logic [7:0] heldByte = 0;
  int holdErr = 0;
  int doneCnt = 0;
  int doneCyc = 0;
  int lastAccCyc = 0;
  logic [7:0] gotQ[$];
  logic [7:0] expQ[$];
  bit bitQ[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    case (readyMode)
      0: byteReady = 1'b1;
      1: byteReady = cyc[0];
      default: begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        byteReady = lfsr[0] | lfsr[2];
      end
    endcase
    if (holdPrev && (!byteValid || byteData != heldByte)) holdErr++;
    holdPrev = byteValid && !byteReady;
    heldByte = byteData;
    if (byteValid && byteReady) begin
      gotQ.push_back(byteData);
      lastAccCyc = cyc;
    end
    if (doneOut) begin
      doneCnt++;
      doneCyc = cyc;
    end
  end

  initial begin
    wait (cyc > 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // Reference bit model
  task automatic addBits(input longint v, input int n);
    for (int i = n - 1; i >= 0; i--) bitQ.push_back(v[i]);
  endtask

  task automatic addUe(input int v);
    int n = 0;
    for (int i = 0; i < 20; i++) if (((v + 1) >> i) & 1) n = i + 1;
    addBits(v + 1, 2 * n - 1);
  endtask

  task automatic closeUnit();
    addBits(1, 1);
    while (bitQ.size() % 8 != 0) bitQ.push_back(1'b0);
  endtask

  task automatic buildExp(input int w, input int h, input bit pre);
    bitQ.delete();
    expQ.delete();
    if (pre) addBits(1, 32);
    addBits(8'h67, 8); addBits(66, 8); addBits(0, 8); addBits(40, 8);
    addUe(0); addUe(0); addUe(2); addUe(1); addBits(0, 1);
    addUe(w); addUe(h);
    addBits(1, 1); addBits(1, 1); addBits(0, 1); addBits(0, 1);
    closeUnit();
    if (pre) addBits(1, 32);
    addBits(8'h68, 8); addUe(0); addUe(0); addBits(0, 1); addBits(0, 1);
    addUe(0); addUe(0); addUe(0); addBits(0, 1); addBits(0, 2);
    addBits(1, 1); addBits(1, 1); addBits(1, 1);
    addBits(0, 1); addBits(0, 1); addBits(0, 1);
    closeUnit();
    for (int i = 0; i < bitQ.size(); i += 8) begin
      logic [7:0] b;
      for (int k = 0; k < 8; k++) b[7-k] = bitQ[i+k];
      expQ.push_back(b);
    end
  endtask

  task automatic pulseStart(input int w, input int h, input bit pre);
    @(negedge clk);
    widthMbsM1 = 9'(w);
    heightMbsM1 = 9'(h);
    prefixEn = pre;
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
  endtask

  task automatic waitDone();
    int t = 0;
    while (doneCnt == 0 && t < 20000) begin
      @(negedge clk);
      t++;
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic compareOut(input string req);
    int mism = 0;
    check(gotQ.size() == expQ.size(), {req, " byte count"}, gotQ.size(), expQ.size());
    for (int i = 0; i < expQ.size() && i < gotQ.size(); i++)
      if (gotQ[i] !== expQ[i]) begin
        mism++;
        $display("FAIL %s byte %0d actual=%02h expected=%02h", req, i, gotQ[i], expQ[i]);
      end
    total++;
    if (mism != 0) bad++;
  endtask

  task automatic runCase(input int w, input int h, input bit pre, input int mode, input string req);
    buildExp(w, h, pre);
    gotQ.delete();
    doneCnt = 0;
    holdErr = 0;
    readyMode = mode;
    pulseStart(w, h, pre);
    waitDone();
    compareOut(req);
    check(doneCnt == 1, "R8 done count", doneCnt, 1);
    check(doneCyc == lastAccCyc + 2, "R8 done timing", doneCyc, lastAccCyc + 2);
    check(holdErr == 0, "R7 hold under stall", holdErr, 0);
  endtask

  task automatic testLiteral352();
    logic [7:0] lit[12] = '{8'h67, 8'h42, 8'h00, 8'h28, 8'hDA, 8'h05, 8'h82, 8'h59,
                            8'h68, 8'hCE, 8'h38, 8'h80};
    runCase(21, 17, 1'b0, 0, "R2 R3 R6 sps/pps 352x288");
    check(gotQ.size() == 12, "R5 no prefix length", gotQ.size(), 12);
    for (int i = 0; i < 12; i++) begin
      logic [7:0] g = (i < gotQ.size()) ? gotQ[i] : 8'hxx;
      check(g === lit[i], (i < 8) ? "R2 literal sps byte" : "R3 literal pps byte", g, lit[i]);
    end
  endtask

  task automatic testPrefix();
    runCase(21, 17, 1'b1, 0, "R5 prefixed units");
    check(gotQ.size() == 20, "R5 prefix length", gotQ.size(), 20);
    if (gotQ.size() == 20) begin
      check({gotQ[0], gotQ[1], gotQ[2], gotQ[3]} == 32'h1, "R5 first start code",
            {gotQ[0], gotQ[1], gotQ[2], gotQ[3]}, 1);
      check({gotQ[12], gotQ[13], gotQ[14], gotQ[15]} == 32'h1, "R5 second start code",
            {gotQ[12], gotQ[13], gotQ[14], gotQ[15]}, 1);
    end
  endtask

  task automatic testBusyStart();
    buildExp(21, 17, 1'b1);
    gotQ.delete();
    doneCnt = 0;
    holdErr = 0;
    readyMode = 1;
    pulseStart(21, 17, 1'b1);
    repeat (15) @(negedge clk);
    widthMbsM1 = 9'd79;
    heightMbsM1 = 9'd44;
    prefixEn = 1'b0;
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    waitDone();
    compareOut("R9 busy start ignored");
    check(doneCnt == 1, "R9 single done", doneCnt, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(byteValid == 1'b0, "R1 reset valid", byteValid, 0);
    check(doneOut == 1'b0, "R1 reset done", doneOut, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(byteValid == 1'b0, "R1 idle valid", byteValid, 0);

    testLiteral352();
    testPrefix();
    runCase(79, 44, 1'b1, 0, "R4 1280x720");
    runCase(0, 0, 1'b0, 1, "R4 R6 1x1 alternating ready");
    runCase(119, 67, 1'b1, 2, "R4 R7 1920x1088 random ready");
    runCase(511, 300, 1'b0, 2, "R4 R7 wide codes random ready");
    testBusyStart();
    runCase(21, 17, 1'b1, 1, "R10 repeat pass");
    runCase(21, 17, 1'b1, 0, "R10 repeat pass again");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule